// File: doc/BRIEF.md
# Transmit Phase-Align Buffer

This block carries a stream of 10-bit transmit characters, each with a one-bit special-character flag, from the clock that captures them into the internal reference character clock. The capture clock may be the reference clock itself or may run at a phase that bears no fixed relation to it. After an initialization the block locks onto the phase it sees between the two clocks. It then absorbs slow drift in either direction inside a fixed occupancy window and delivers one character per reference cycle, in order.

When drift leaves the window, a sticky phase-error flag is raised. For as long as the flag stays high, the output carries a fixed error character on every cycle instead of buffered data. The flag clears in two ways: a full reinitialization, or a word-sync request when word-sync mode is enabled. The word-sync request re-centres the read position in place, and the only cost is a small jump in the outgoing stream. A bypass select routes the captured character straight to the output register when the capture clock is the reference clock. This gives the lowest latency.

Top module: `tx_phase_align`

## Requirements
- R1: While the internal reset is active, `out_valid`, `phase_err`, `out_code` and `out_sc` are all 0.
- R2: `tx_rst_n` is asynchronous and is synchronized to `ref_clk`. Initialization starts only when the input has been sampled low on two consecutive `ref_clk` rising edges. A low level caught by a single edge has no effect, and an existing phase error survives it.
- R3: After initialization, `out_valid` stays low until characters written after the reset have reached the centre fill level. It is low for at least the first four reference cycles after `tx_rst_n` returns high, and it rises within 40 cycles when the write clock runs.
- R4: With the write clock at the reference frequency and any fixed phase offset, characters leave in the order they were written, with none lost or repeated, and `phase_err` stays 0.
- R5: The special-character flag leaves the block together with the character it was written with.
- R6: If the write clock is slower than the reference clock, the synchronized fill level eventually falls to 0 and `phase_err` goes to 1.
- R7: If the write clock is faster than the reference clock, the synchronized fill level reaches twice the centre value (4 by default) and `phase_err` goes to 1. No character is corrupted before the flag rises.
- R8: `phase_err` stays at 1 once set, even after the clocks match again. It clears only through R2 initialization, the R10 re-centre, or bypass.
- R9: While `phase_err` is 1, every cycle outputs `out_valid`=1, `out_code` equal to the error-character parameter (default 10'h2F8) and `out_sc`=0.
- R10: With `wsync_mode`=1, a word-sync request sampled while `phase_err`=1 clears the flag on that edge. It also drops `out_valid` for one cycle, after which the stream resumes in order. With `wsync_mode`=0 the request is ignored.
- R11: With `bypass_sel`=1, the character present at a `ref_clk` edge appears on the outputs after that edge, with `out_valid`=1. `phase_err` reads 0 from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Internal reference character clock (read side) |
| wr_clk | input | 1 | Capture clock of the incoming characters |
| tx_rst_n | input | 1 | Asynchronous active-low initialization request |
| bypass_sel | input | 1 | 1: skip the buffer (capture clock is `ref_clk`) |
| wsync_mode | input | 1 | Enables re-centring on a word-sync request |
| wsync_req | input | 1 | Word-sync sequence being sent, `ref_clk` domain |
| in_code | input | 10 | Incoming character, `wr_clk` domain |
| in_sc | input | 1 | Special-character flag of the incoming character |
| out_code | output | 10 | Outgoing character, `ref_clk` domain |
| out_sc | output | 1 | Special-character flag of the outgoing character |
| out_valid | output | 1 | Outgoing character is meaningful |
| phase_err | output | 1 | Sticky drift-window error |

## Verification
The main function is exercised with a write clock matched to the reference clock at three phase offsets, which separates true phase tolerance from lucky edge alignment. It is also exercised with a write clock 5% slower and one 5% faster, which separates underflow detection from overflow detection. Each run streams an incrementing counter and derives the flag from the counter bits, so any lost, repeated or mismatched character shows up as a continuity break. Directed runs then cover stickiness, re-centring with and without word-sync mode, single-edge reset glitches and bypass.

// File: rtl/pab_pkg.sv
`timescale 1ns/1ps
package pab_pkg;

    localparam int CHAR_W = 10;

    typedef struct packed {
        logic              sc;
        logic [CHAR_W-1:0] code;
    } pab_char_t;

    typedef enum logic [1:0] {
        RD_WAIT  = 2'd0,
        RD_RUN   = 2'd1,
        RD_FAULT = 2'd2
    } rd_state_e;

    localparam logic [CHAR_W-1:0] DEFAULT_ERR_CODE = 10'h2F8;

    function automatic pab_char_t err_char(input logic [CHAR_W-1:0] code);
        pab_char_t c;
        c.sc   = 1'b0;
        c.code = code;
        return c;
    endfunction

endpackage

// File: rtl/pab_rst_filter.sv
`timescale 1ns/1ps
module pab_rst_filter #(
    parameter int HOLD = 8,
    localparam int HW = $clog2(HOLD + 1)
) (
    input  logic clk,
    input  logic rst_n_async,
    output logic rst
);
    logic [2:0]    smp;
    logic [HW-1:0] hold_cnt;
    logic          two_low;

    // smp[0] absorbs metastability; smp[1] and smp[2] are two successive edges
    assign two_low = ~smp[1] & ~smp[2];

    always_ff @(posedge clk) begin
        smp <= {smp[1:0], rst_n_async};
        if (two_low)
            hold_cnt <= HW'(HOLD);
        else if (hold_cnt != '0)
            hold_cnt <= hold_cnt - 1'b1;
    end

    assign rst = two_low | (hold_cnt != '0);
endmodule

// File: rtl/pab_sync.sv
`timescale 1ns/1ps
module pab_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         clr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1, s2;

    always_ff @(posedge clk) begin
        if (clr) begin
            s1 <= INIT;
            s2 <= INIT;
        end else begin
            s1 <= d;
            s2 <= s1;
        end
    end

    assign q = s2;
endmodule

// File: rtl/pab_store.sv
`timescale 1ns/1ps
module pab_store import pab_pkg::*; #(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          wr_clk,
    input  logic          wr_rst,
    input  pab_char_t     wr_char,
    output logic [PW-1:0] wr_gray,
    input  logic [AW-1:0] rd_addr,
    output pab_char_t     rd_char
);
    pab_char_t     mem [DEPTH];
    logic [PW-1:0] wr_bin;
    logic [PW-1:0] wr_next;

    assign wr_next = wr_bin + 1'b1;

    always_ff @(posedge wr_clk) begin
        if (wr_rst) begin
            wr_bin  <= '0;
            wr_gray <= '0;
        end else begin
            wr_bin  <= wr_next;
            wr_gray <= wr_next ^ (wr_next >> 1);
        end
    end

    always_ff @(posedge wr_clk) begin
        if (!wr_rst)
            mem[wr_bin[AW-1:0]] <= wr_char;
    end

    assign rd_char = mem[rd_addr];
endmodule

// File: rtl/pab_reader.sv
`timescale 1ns/1ps
module pab_reader import pab_pkg::*; #(
    parameter int DEPTH  = 8,
    parameter int CENTER = 2,
    parameter logic [CHAR_W-1:0] ERR_CODE = DEFAULT_ERR_CODE,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1,
    localparam int LIMIT = 2 * CENTER
) (
    input  logic          ref_clk,
    input  logic          rd_rst,
    input  logic          bypass_sel,
    input  logic          wsync_mode,
    input  logic          wsync_req,
    input  logic [PW-1:0] wr_gray_s,
    output logic [AW-1:0] rd_addr,
    input  pab_char_t     rd_char,
    input  pab_char_t     byp_char,
    output pab_char_t     out_char,
    output logic          out_valid,
    output logic          phase_err
);
    rd_state_e     state;
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_bin_s;
    logic [PW-1:0] occ;
    logic          at_edge;
    logic          recenter;

    always_comb begin
        for (int i = 0; i < PW; i++)
            wr_bin_s[i] = ^(wr_gray_s >> i);
    end

    assign occ      = wr_bin_s - rd_ptr;
    assign at_edge  = (occ == '0) || (occ >= PW'(LIMIT));
    assign recenter = wsync_mode && wsync_req;
    assign rd_addr  = rd_ptr[AW-1:0];

    always_ff @(posedge ref_clk) begin
        if (rd_rst) begin
            state     <= RD_WAIT;
            rd_ptr    <= '0;
            out_char  <= '0;
            out_valid <= 1'b0;
        end else if (bypass_sel) begin
            state     <= RD_RUN;
            rd_ptr    <= wr_bin_s - PW'(CENTER);
            out_char  <= byp_char;
            out_valid <= 1'b1;
        end else begin
            unique case (state)
                RD_WAIT: begin
                    if (occ >= PW'(CENTER))
                        state <= RD_RUN;
                end
                RD_RUN: begin
                    out_valid <= 1'b1;
                    if (at_edge) begin
                        state    <= RD_FAULT;
                        out_char <= err_char(ERR_CODE);
                    end else begin
                        out_char <= rd_char;
                        rd_ptr   <= rd_ptr + 1'b1;
                    end
                end
                RD_FAULT: begin
                    if (recenter) begin
                        state     <= RD_RUN;
                        rd_ptr    <= wr_bin_s - PW'(CENTER);
                        out_valid <= 1'b0;
                    end else begin
                        out_char  <= err_char(ERR_CODE);
                        out_valid <= 1'b1;
                    end
                end
                default: state <= RD_WAIT;
            endcase
        end
    end

    assign phase_err = (state == RD_FAULT);
endmodule

// File: rtl/tx_phase_align.sv
`timescale 1ns/1ps
module tx_phase_align import pab_pkg::*; #(
    parameter int DEPTH    = 8,
    parameter int CENTER   = 2,
    parameter int RST_HOLD = 8,
    parameter logic [CHAR_W-1:0] ERR_CODE = DEFAULT_ERR_CODE,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic              ref_clk,
    input  logic              wr_clk,
    input  logic              tx_rst_n,
    input  logic              bypass_sel,
    input  logic              wsync_mode,
    input  logic              wsync_req,
    input  logic [CHAR_W-1:0] in_code,
    input  logic              in_sc,
    output logic [CHAR_W-1:0] out_code,
    output logic              out_sc,
    output logic              out_valid,
    output logic              phase_err
);
    logic          rd_rst;
    logic          wr_rst;
    logic [PW-1:0] wr_gray;
    logic [PW-1:0] wr_gray_s;
    logic [AW-1:0] rd_addr;
    pab_char_t     in_char;
    pab_char_t     rd_char;
    pab_char_t     out_char;

    assign in_char.code = in_code;
    assign in_char.sc   = in_sc;

    pab_rst_filter #(.HOLD(RST_HOLD)) u_rst (
        .clk(ref_clk), .rst_n_async(tx_rst_n), .rst(rd_rst)
    );

    pab_sync #(.W(1), .INIT(1'b1)) u_wr_rst_sync (
        .clk(wr_clk), .clr(1'b0), .d(rd_rst), .q(wr_rst)
    );

    pab_store #(.DEPTH(DEPTH)) u_store (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_char(in_char),
        .wr_gray(wr_gray), .rd_addr(rd_addr), .rd_char(rd_char)
    );

    pab_sync #(.W(PW)) u_ptr_sync (
        .clk(ref_clk), .clr(rd_rst), .d(wr_gray), .q(wr_gray_s)
    );

    pab_reader #(.DEPTH(DEPTH), .CENTER(CENTER), .ERR_CODE(ERR_CODE)) u_reader (
        .ref_clk(ref_clk), .rd_rst(rd_rst), .bypass_sel(bypass_sel),
        .wsync_mode(wsync_mode), .wsync_req(wsync_req),
        .wr_gray_s(wr_gray_s), .rd_addr(rd_addr), .rd_char(rd_char),
        .byp_char(in_char), .out_char(out_char),
        .out_valid(out_valid), .phase_err(phase_err)
    );

    assign out_code = out_char.code;
    assign out_sc   = out_char.sc;
endmodule

// File: rtl/pab_chk.sv
`timescale 1ns/1ps
module pab_chk #(
    parameter logic [9:0] ERR_CODE = 10'h2F8
) (
    input logic       ref_clk,
    input logic       rd_rst,
    input logic       bypass_sel,
    input logic       wsync_mode,
    input logic       wsync_req,
    input logic [9:0] out_code,
    input logic       out_sc,
    input logic       out_valid,
    input logic       phase_err
);
    // R1
    reset_quiet_chk: assert property (@(posedge ref_clk)
        rd_rst |=> (!out_valid && !phase_err && out_code == '0 && !out_sc));

    // R8
    err_sticky_chk: assert property (@(posedge ref_clk) disable iff (rd_rst)
        (phase_err && !bypass_sel && !(wsync_mode && wsync_req)) |=> phase_err);

    // R9
    err_char_chk: assert property (@(posedge ref_clk) disable iff (rd_rst)
        phase_err |-> (out_valid && out_code == ERR_CODE && !out_sc));

    // R10
    recenter_chk: assert property (@(posedge ref_clk) disable iff (rd_rst)
        (phase_err && wsync_mode && wsync_req && !bypass_sel) |=> (!phase_err && !out_valid));

    // R11
    bypass_clear_chk: assert property (@(posedge ref_clk) disable iff (rd_rst)
        bypass_sel |=> (!phase_err && out_valid));
endmodule

bind tx_phase_align pab_chk #(.ERR_CODE(ERR_CODE)) u_chk (
    .ref_clk(ref_clk), .rd_rst(rd_rst), .bypass_sel(bypass_sel),
    .wsync_mode(wsync_mode), .wsync_req(wsync_req),
    .out_code(out_code), .out_sc(out_sc),
    .out_valid(out_valid), .phase_err(phase_err)
);

// File: tb/test_tx_phase_align.sv
`timescale 1ns/1ps
module test_tx_phase_align;

    localparam logic [9:0] ERR = 10'h2F8;

    typedef struct packed {
        int   half_ps;
        int   shift_ps;
        int   cycles;
        logic exp_err;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{5000, 0,    600, 1'b0},
        '{5000, 3000, 600, 1'b0},
        '{5000, 7000, 600, 1'b0},
        '{5250, 0,    600, 1'b1},
        '{4750, 0,    600, 1'b1}
    };

    logic ref_clk = 0, wr_clk = 0;
    realtime wr_half = 5.0, wr_shift = 0.0;
    logic tx_rst_n = 0, bypass_sel = 0, wsync_mode = 0, wsync_req = 0;
    logic [9:0] in_code = '0;
    logic in_sc = 0;
    logic [9:0] out_code;
    logic out_sc, out_valid, phase_err;

    int checks = 0, errors = 0;
    bit done = 0;
    bit hold_drv = 0;
    logic [9:0] gen_cnt = '0;

    bit mon_on = 0, prev_ok = 0;
    logic [9:0] prev_code = '0;
    int seq_bad = 0, sc_bad = 0, errchar_bad = 0;

    tx_phase_align i_tx_phase_align (
        .ref_clk(ref_clk), .wr_clk(wr_clk), .tx_rst_n(tx_rst_n),
        .bypass_sel(bypass_sel), .wsync_mode(wsync_mode), .wsync_req(wsync_req),
        .in_code(in_code), .in_sc(in_sc), .out_code(out_code), .out_sc(out_sc),
        .out_valid(out_valid), .phase_err(phase_err)
    );

    initial forever #5 ref_clk = ~ref_clk;

    initial begin
        forever begin
            #(wr_half);
            wr_clk = ~wr_clk;
            if (wr_shift > 0.0) begin
                #(wr_shift);
                wr_shift = 0.0;
            end
        end
    end

    always @(negedge wr_clk) begin
        if (!hold_drv) begin
            in_code = gen_cnt;
            in_sc   = gen_cnt[2] ^ gen_cnt[7];
            gen_cnt = gen_cnt + 10'd1;
        end
    end

    always @(negedge ref_clk) begin
        if (mon_on) begin
            if (out_valid && !phase_err) begin
                if (out_sc !== (out_code[2] ^ out_code[7])) sc_bad++;
                if (prev_ok && out_code !== 10'(prev_code + 10'd1)) seq_bad++;
                prev_ok   = 1;
                prev_code = out_code;
            end else begin
                prev_ok = 0;
            end
            if (phase_err && (out_code !== ERR || out_sc !== 1'b0 || out_valid !== 1'b1))
                errchar_bad++;
        end else begin
            prev_ok = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic do_reset(input int low_cycles);
        @(negedge ref_clk);
        tx_rst_n = 0;
        repeat (low_cycles) @(negedge ref_clk);
        tx_rst_n = 1;
    endtask

    task automatic clear_mon();
        seq_bad = 0; sc_bad = 0; errchar_bad = 0;
    endtask

    task automatic pulse_wsync();
        @(negedge ref_clk);
        wsync_req = 1;
        @(negedge ref_clk);
        wsync_req = 0;
    endtask

    initial begin
        int wait_n;
        // R1: outputs quiet during reset
        cyc(3);
        do_reset(6);
        chk(out_valid === 1'b0 && phase_err === 1'b0, "R1 flags in reset", {out_valid, phase_err}, 0);
        chk(out_code === 10'h0 && out_sc === 1'b0, "R1 data in reset", out_code, 0);

        // R3: valid low for first four cycles, then rises
        for (int k = 0; k < 4; k++) begin
            chk(out_valid === 1'b0, "R3 valid early", out_valid, 0);
            cyc(1);
        end
        wait_n = 0;
        while (out_valid !== 1'b1 && wait_n < 40) begin
            cyc(1);
            wait_n++;
        end
        chk(out_valid === 1'b1, "R3 valid rises", out_valid, 1);

        // R4 R5 R6 R7 R9: pattern table
        for (int i = 0; i < NV; i++) begin
            wr_half  = VECS[i].half_ps / 1000.0;
            wr_shift = VECS[i].shift_ps / 1000.0;
            do_reset(4);
            cyc(30);
            clear_mon();
            mon_on = 1;
            cyc(VECS[i].cycles);
            mon_on = 0;
            chk(phase_err === VECS[i].exp_err,
                VECS[i].exp_err ? "R6/R7 drift flagged" : "R4 no error at matched rate",
                phase_err, VECS[i].exp_err);
            chk(seq_bad == 0, "R4 R7 order preserved", seq_bad, 0);
            chk(sc_bad == 0, "R5 flag follows char", sc_bad, 0);
            chk(errchar_bad == 0, "R9 error char", errchar_bad, 0);
        end

        // R8: sticky after clocks match again (last vector left error set)
        wr_half = 5.0;
        cyc(200);
        chk(phase_err === 1'b1, "R8 sticky", phase_err, 1);

        // R10: ignored without word-sync mode
        wsync_mode = 0;
        pulse_wsync();
        cyc(3);
        chk(phase_err === 1'b1, "R10 ignored when mode off", phase_err, 1);

        // R10: recenter clears the error and stream resumes
        wsync_mode = 1;
        @(negedge ref_clk);
        wsync_req = 1;
        @(negedge ref_clk);
        wsync_req = 0;
        chk(phase_err === 1'b0 && out_valid === 1'b0, "R10 recenter clears", {phase_err, out_valid}, 0);
        cyc(5);
        clear_mon();
        mon_on = 1;
        cyc(300);
        mon_on = 0;
        chk(phase_err === 1'b0, "R10 stable after recenter", phase_err, 0);
        chk(seq_bad == 0 && sc_bad == 0, "R10 in order after recenter", seq_bad + sc_bad, 0);
        wsync_mode = 0;

        // R2: a low seen by one edge does not initialize
        wr_half = 5.25;
        cyc(300);
        chk(phase_err === 1'b1, "R6 slow write precondition", phase_err, 1);
        wr_half = 5.0;
        do_reset(1);
        cyc(6);
        chk(phase_err === 1'b1, "R2 single-edge low ignored", phase_err, 1);
        do_reset(2);
        cyc(3);
        chk(phase_err === 1'b0 && out_valid === 1'b0, "R2 two-edge low initializes",
            {phase_err, out_valid}, 0);

        // R11: bypass, entered while in error
        wr_half = 5.25;
        cyc(300);
        chk(phase_err === 1'b1, "R6 error before bypass", phase_err, 1);
        wr_half = 5.0;
        hold_drv = 1;
        @(negedge ref_clk);
        bypass_sel = 1;
        in_code = 10'h155;
        in_sc = 1;
        @(negedge ref_clk);
        chk(out_code === 10'h155 && out_sc === 1'b1 && out_valid === 1'b1,
            "R11 bypass data", {out_sc, out_code}, {1'b1, 10'h155});
        chk(phase_err === 1'b0, "R11 bypass clears error", phase_err, 0);
        in_code = 10'h2AA;
        in_sc = 0;
        @(negedge ref_clk);
        chk(out_code === 10'h2AA && out_sc === 1'b0, "R11 bypass second", {out_sc, out_code}, {1'b0, 10'h2AA});

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400us;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule